// File: doc/BRIEF.md
# Nibble-Register Three-Wire Serial Master

This block talks to a clock chip that exposes sixteen 4-bit registers over three lines: a serial clock that rests high, a data line the master drives only while its output enable is on, and a chip enable. The host hands over one register access at a time. For a write it sends a command byte that carries the address, then a byte that carries the 4-bit value. For a read it sends a command byte and then clocks in a full byte, of which only the low nibble is returned. Bit timing is slow and symmetric: each half of a serial clock period lasts `HALF_CYC` system clocks. The default of 175 gives about 700 ns at 250 MHz.

Requests use a valid/ready handshake. `req_ready` is high only while the master is idle, and a request is taken on the edge where `req_valid` and `req_ready` are both high. While an access is running, `req_ready` stays low, so the host holds its request or retries later. The result comes back as a single-cycle `done` pulse with `rd_data`, and no back-pressure applies to it: the host must capture it in that cycle. A new request may be offered in the same cycle as `done`. The `DRIVE_CE` parameter selects whether the master raises chip enable for each access itself or holds its chip-enable pin low and leaves enable framing to a sequencer outside.

Top module: `nib3w_master`

## Requirements
- R1: After reset and while idle: `ce_o`=0, `scl_o`=1, `sda_oe`=0, `busy`=0, `done`=0 and `req_ready`=1.
- R2: A write first shifts out, MSB first, a command byte with bit 5 = 1, bits 7, 6 and 4 = 0, and the address in bits 3:0.
- R3: A write then shifts out a second byte with the write data in bits 3:0, bit 4 = 1 and bits 7:5 = 0.
- R4: A read shifts out one command byte with bits 6 and 5 = 1, bits 7 and 4 = 0 and the address in bits 3:0. It then runs 8 input clock periods, and `sda_oe` stays low for all of them.
- R5: Every bit period is `HALF_CYC` cycles with `scl_o` high, then `HALF_CYC` cycles with `scl_o` low. For an output bit, `sda_o` holds the bit value through both halves.
- R6: `sda_oe` is high for exactly the 16 half periods of each output byte. It is low during the `HALF_CYC`-cycle gap that follows the first byte, and at all other times.
- R7: An input bit is sampled from `sda_i` at the end of its clock-high half. `rd_data` equals the last four bits received (bits 3:0 of the MSB-first byte), and the upper four are dropped.
- R8: A request is accepted only when `req_valid` and `req_ready` are both high. `req_ready` is low and `busy` is high from the cycle after acceptance until the access ends. A request offered while busy changes nothing on the serial lines.
- R9: `done` pulses for one cycle, in the first idle cycle after an access, with `rd_data` valid. `rd_data` is 0 for a write.
- R10: With `DRIVE_CE`=0, `ce_o` stays 0 while `scl_o` and `sda_oe` behave exactly as they do with `DRIVE_CE`=1.
- R11: With `DRIVE_CE`=1, `ce_o` is high from the cycle after acceptance until `done`. This span includes a `HALF_CYC`-cycle setup before the first bit and a `HALF_CYC`-cycle hold after the last one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Master idle, request can be taken |
| req_read | input | 1 | 1 = register read, 0 = register write |
| req_addr | input | 4 | Register address |
| req_wdata | input | 4 | Write value |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle end-of-access pulse |
| rd_data | output | 4 | Read nibble, valid with done |
| scl_o | output | 1 | Serial clock, idles high |
| sda_o | output | 1 | Serial data out |
| sda_oe | output | 1 | Serial data output enable |
| sda_i | input | 1 | Serial data in |
| ce_o | output | 1 | Chip enable (held 0 when DRIVE_CE=0) |

## Verification
The hardest case to reach from the ports is a request that arrives while an access is already running. The stimulus raises `req_valid` with different fields partway through a read and drops it again well before `done`. The cycle-accurate model then shows that the serial waveform and the result are those of the original access. The sampling instant is also hard to pin down. To expose it, the bench's slave model drives the true bit only during the clock-high half and the inverted bit during the low half, so sampling one cycle late or early returns the wrong nibble. Offering the next request in the same cycle as `done` exercises back-to-back acceptance.

// File: rtl/nib3w_pkg.sv
package nib3w_pkg;
  localparam int NIB_W   = 4;
  localparam int BYTE_W  = 8;
  localparam int FLAG_RD = 6;
  localparam int FLAG_AP = 5;
  localparam int FLAG_DP = 4;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SETUP, ST_TX_HI, ST_TX_LO, ST_GAP, ST_RX_HI, ST_RX_LO, ST_HOLD
  } phase_e;

  function automatic logic [BYTE_W-1:0] cmd_byte(input logic rd,
                                                 input logic [NIB_W-1:0] addr);
    logic [BYTE_W-1:0] b;
    b = '0;
    b[NIB_W-1:0] = addr;
    b[FLAG_AP] = 1'b1;
    b[FLAG_RD] = rd;
    return b;
  endfunction

  function automatic logic [BYTE_W-1:0] data_byte(input logic [NIB_W-1:0] d);
    logic [BYTE_W-1:0] b;
    b = '0;
    b[NIB_W-1:0] = d;
    b[FLAG_DP] = 1'b1;
    return b;
  endfunction
endpackage

// File: rtl/nib3w_halftimer.sv
module nib3w_halftimer #(
  parameter int HALF = 175
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF - 1);

  logic [CW-1:0] cnt;

  assign tick = run && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)             cnt <= '0;
    else if (!run || tick)  cnt <= '0;
    else                    cnt <= cnt + 1'b1;
  end

  // R5: a half period never runs past its programmed length
  a_r5_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);
endmodule

// File: rtl/nib3w_shiftbyte.sv
module nib3w_shiftbyte #(
  parameter int W     = 8,
  parameter int LOW_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [W-1:0]     load_val,
  input  logic             shift_en,
  input  logic             shift_bit,
  input  logic             step,
  output logic             msb,
  output logic [LOW_W-1:0] low,
  output logic             last
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] TOP = CW'(W - 1);

  logic [W-1:0]  data;
  logic [CW-1:0] bitcnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data   <= '0;
      bitcnt <= '0;
    end else if (load) begin
      data   <= load_val;
      bitcnt <= '0;
    end else begin
      if (shift_en) data <= {data[W-2:0], shift_bit};
      if (step)     bitcnt <= (bitcnt == TOP) ? '0 : bitcnt + 1'b1;
    end
  end

  assign msb  = data[W-1];
  assign low  = data[LOW_W-1:0];
  assign last = (bitcnt == TOP);

  // R6: the sequencer never reloads and shifts in the same cycle
  a_r6_load_shift_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(load && shift_en));
endmodule

// File: rtl/nib3w_master.sv
module nib3w_master
  import nib3w_pkg::*;
#(
  parameter int HALF_CYC = 175,
  parameter bit DRIVE_CE = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_read,
  input  logic [NIB_W-1:0] req_addr,
  input  logic [NIB_W-1:0] req_wdata,
  output logic             busy,
  output logic             done,
  output logic [NIB_W-1:0] rd_data,
  output logic             scl_o,
  output logic             sda_o,
  output logic             sda_oe,
  input  logic             sda_i,
  output logic             ce_o
);
  phase_e            st;
  logic              second, is_rd, tick, last;
  logic [NIB_W-1:0]  wbuf, sh_low;
  logic              ld, sh_en, stp;
  logic [BYTE_W-1:0] ld_val;

  nib3w_halftimer #(.HALF(HALF_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(st != ST_IDLE), .tick(tick));

  assign ld     = (st == ST_IDLE && req_valid) ||
                  (st == ST_TX_LO && tick && last && !second);
  assign ld_val = (st == ST_IDLE) ? cmd_byte(req_read, req_addr)
                                  : (is_rd ? '0 : data_byte(wbuf));
  assign sh_en  = tick && ((st == ST_TX_LO && !last) || st == ST_RX_HI);
  assign stp    = tick && (st == ST_TX_LO || st == ST_RX_LO);

  nib3w_shiftbyte #(.W(BYTE_W), .LOW_W(NIB_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(ld), .load_val(ld_val),
    .shift_en(sh_en), .shift_bit(sda_i), .step(stp),
    .msb(sda_o), .low(sh_low), .last(last));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      second  <= 1'b0;
      is_rd   <= 1'b0;
      wbuf    <= '0;
      rd_data <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (st)
        ST_IDLE: if (req_valid) begin
          st      <= ST_SETUP;
          is_rd   <= req_read;
          wbuf    <= req_wdata;
          second  <= 1'b0;
          rd_data <= '0;
        end
        ST_SETUP: if (tick) st <= ST_TX_HI;
        ST_TX_HI: if (tick) st <= ST_TX_LO;
        ST_TX_LO: if (tick) begin
          if (!last)       st <= ST_TX_HI;
          else if (second) st <= ST_HOLD;
          else             st <= ST_GAP;
        end
        ST_GAP: if (tick) begin
          second <= 1'b1;
          st     <= is_rd ? ST_RX_HI : ST_TX_HI;
        end
        ST_RX_HI: if (tick) st <= ST_RX_LO;
        ST_RX_LO: if (tick) begin
          if (last) begin
            rd_data <= sh_low;
            st      <= ST_HOLD;
          end else begin
            st <= ST_RX_HI;
          end
        end
        ST_HOLD: if (tick) begin
          st   <= ST_IDLE;
          done <= 1'b1;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign busy      = (st != ST_IDLE);
  assign req_ready = (st == ST_IDLE);
  assign scl_o     = !(st == ST_TX_LO || st == ST_RX_LO);
  assign sda_oe    = (st == ST_TX_HI || st == ST_TX_LO);

  generate
    if (DRIVE_CE) begin : g_ce_own
      assign ce_o = busy;
    end else begin : g_ce_ext
      assign ce_o = 1'b0;
    end
  endgenerate

  // R8: an accepted request starts an access on the next cycle
  a_r8_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> busy);
  // R9: done only ends an access that was running
  a_r9_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(busy) && !busy));
  // R6: output enable only inside an access
  a_r6_oe_in_access: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe |-> busy);
  // R6: output enable never turns on in a clock-low half
  a_r6_oe_rise_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> scl_o);
  // R4: data line released during the input byte
  a_r4_rx_released: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RX_HI || st == ST_RX_LO) |-> !sda_oe);
  // R5: output bit unchanged across the clock-low half
  a_r5_sda_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_TX_LO) |-> $stable(sda_o));
endmodule

// File: tb/nib3w_master_tb.sv
module nib3w_master_tb_top;
  localparam int HALF = 3;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n, req_valid, req_read, sda_i;
  logic [3:0] req_addr, req_wdata;
  logic       req_ready, busy, done, scl_o, sda_o, sda_oe, ce_o;
  logic [3:0] rd_data;
  logic       rdy_n, busy_n, done_n, scl_n, sdo_n, oe_n, ce_n;
  logic [3:0] rd_n;

  nib3w_master #(.HALF_CYC(HALF), .DRIVE_CE(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_read(req_read), .req_addr(req_addr), .req_wdata(req_wdata),
    .busy(busy), .done(done), .rd_data(rd_data), .scl_o(scl_o),
    .sda_o(sda_o), .sda_oe(sda_oe), .sda_i(sda_i), .ce_o(ce_o));

  nib3w_master #(.HALF_CYC(HALF), .DRIVE_CE(1'b0)) dut_nc (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(rdy_n),
    .req_read(req_read), .req_addr(req_addr), .req_wdata(req_wdata),
    .busy(busy_n), .done(done_n), .rd_data(rd_n), .scl_o(scl_n),
    .sda_o(sdo_n), .sda_oe(oe_n), .sda_i(sda_i), .ce_o(ce_n));

  typedef struct {
    bit ce, scl, oe, sda, sda_chk, drv, bsy, dn;
    logic [3:0] rd;
    string tag;
  } exp_t;

  exp_t q[$];
  int total = 0, bad = 0, cyc = 0;
  bit running = 0;

  task automatic chk(bit ok, string req, int act, int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic push_n(int n, bit ce, bit scl, bit oe, bit sda, bit sc,
                        bit drv, string tag);
    for (int i = 0; i < n; i++) begin
      exp_t e;
      e.ce = ce; e.scl = scl; e.oe = oe; e.sda = sda; e.sda_chk = sc;
      e.drv = drv; e.bsy = 1; e.dn = 0; e.rd = 4'h0; e.tag = tag;
      q.push_back(e);
    end
  endtask

  task automatic push_tx(logic [7:0] b, string tag);
    for (int k = 7; k >= 0; k--) begin
      push_n(HALF, 1, 1, 1, b[k], 1, 1, tag);
      push_n(HALF, 1, 0, 1, b[k], 1, 1, tag);
    end
  endtask

  task automatic push_rx(logic [7:0] r);
    for (int k = 7; k >= 0; k--) begin
      push_n(HALF, 1, 1, 0, 0, 0, r[k], "R4");
      push_n(HALF, 1, 0, 0, 0, 0, !r[k], "R4");
    end
  endtask

  task automatic schedule(bit rd, logic [3:0] a, logic [3:0] w, logic [7:0] rx);
    exp_t e;
    push_n(HALF, 1, 1, 0, 0, 0, 1, "R11");
    push_tx({1'b0, rd, 1'b1, 1'b0, a}, rd ? "R4" : "R2");
    push_n(HALF, 1, 1, 0, 0, 0, 1, "R6");
    if (rd) push_rx(rx);
    else    push_tx({4'b0001, w}, "R3");
    push_n(HALF, 1, 1, 0, 0, 0, 1, "R11");
    e.ce = 0; e.scl = 1; e.oe = 0; e.sda = 0; e.sda_chk = 0; e.drv = 1;
    e.bsy = 0; e.dn = 1; e.rd = rd ? rx[3:0] : 4'h0; e.tag = "R9";
    q.push_back(e);
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(negedge clk) begin
    if (running) begin
      exp_t e;
      bit idle;
      cyc++;
      if (cyc > 50000) begin
        total++; bad++;
        $display("FAIL watchdog actual=%0d expected=<50000", cyc);
        finish_run();
      end
      idle = (q.size() == 0);
      if (!idle) e = q.pop_front();
      else begin
        e.ce = 0; e.scl = 1; e.oe = 0; e.sda = 0; e.sda_chk = 0; e.drv = 1;
        e.bsy = 0; e.dn = 0; e.rd = 4'h0; e.tag = "R1";
      end
      sda_i <= e.drv;
      chk(ce_o == e.ce, idle ? "R1 ce" : "R11 ce", ce_o, e.ce);
      chk(scl_o == e.scl, idle ? "R1 scl" : "R5 scl", scl_o, e.scl);
      chk(sda_oe == e.oe, idle ? "R1 oe" : "R6 oe", sda_oe, e.oe);
      if (e.sda_chk) chk(sda_o == e.sda, {e.tag, "/R5 sda"}, sda_o, e.sda);
      chk(busy == e.bsy, "R8 busy", busy, e.bsy);
      chk(req_ready == !e.bsy, "R8 ready", req_ready, !e.bsy);
      chk(done == e.dn, "R9 done", done, e.dn);
      if (e.dn) chk(rd_data == e.rd, "R7/R9 rd_data", rd_data, e.rd);
      chk(ce_n == 1'b0, "R10 ce", ce_n, 0);
      chk(scl_n == scl_o && oe_n == sda_oe, "R10 lines", {scl_n, oe_n},
          {scl_o, sda_oe});
    end
  end

  task automatic do_req(bit rd, logic [3:0] a, logic [3:0] w, logic [7:0] rx);
    @(negedge clk); #1;
    while (q.size() > 1) begin @(negedge clk); #1; end
    if (q.size() == 1) begin @(negedge clk); #1; end
    req_valid = 1; req_read = rd; req_addr = a; req_wdata = w;
    @(posedge clk); #1;
    req_valid = 0;
    schedule(rd, a, w, rx);
  endtask

  initial begin
    rst_n = 0; req_valid = 0; req_read = 0; req_addr = 0; req_wdata = 0;
    sda_i = 1;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(busy == 0 && done == 0 && ce_o == 0, "R1 reset", {busy, done, ce_o}, 0);
    chk(scl_o == 1 && sda_oe == 0 && req_ready == 1, "R1 reset lines",
        {scl_o, sda_oe, req_ready}, 3'b101);
    #1 rst_n = 1; running = 1;
    repeat (4) @(negedge clk);
    do_req(0, 4'h0, 4'hA, 8'h00);
    do_req(0, 4'hF, 4'h5, 8'h00);
    do_req(1, 4'h3, 4'h0, 8'hA5);
    // R8: request offered mid-access must be ignored
    repeat (10) @(negedge clk);
    #1 req_valid = 1; req_read = 0; req_addr = 4'h8; req_wdata = 4'h1;
    repeat (5) @(negedge clk);
    #1 req_valid = 0;
    do_req(1, 4'hC, 4'h0, 8'h3C);   // R7: upper bits dropped
    do_req(1, 4'h7, 4'h0, 8'hF0);
    do_req(1, 4'hE, 4'h0, 8'h0F);
    do_req(0, 4'h9, 4'hF, 8'h00);
    do_req(0, 4'h6, 4'h0, 8'h00);
    while (q.size() > 0) @(negedge clk);
    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule